// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory interface from reset to a usable state. After a start request it walks a fixed bring-up procedure. It first writes the PHY clock enable. It then pulses a PHY control write that resets both the PHY and its calibration logic, and follows that with a calibration-start write. It then waits out the power-up delay before it sends any memory command.

Next it sends the twelve initialization commands to the memory controller's command port, one at a time. Each command goes out on a valid/ready handshake and is followed by a minimum idle gap. The commands cover deselect, precharge-all, the extended mode registers, DLL enable and reset, two refreshes, the mode-register load and the output-driver calibration steps. The sequence closes with three controller register writes: timing, latency and configuration. A done flag then stays high until the next reset.

The command codes and argument encodings are parameters. The mode, timing and configuration values come in on ports.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, every strobe (`phy_cfg_wr`, `phy_ctrl_wr`, `cmd_valid`, `reg_wr`) and `done` are low until `start` is seen.
- R2: A `start` pulse in idle produces three writes in consecutive cycles. The first is `phy_cfg_wr`. The second is `phy_ctrl_wr` with `phy_ctrl_data` = 3'b011 (bit 0 PHY reset, bit 1 calibration reset). The third is `phy_ctrl_wr` with `phy_ctrl_data` = 3'b100 (bit 2 calibration start).
- R3: No command is issued within `WAIT_CYCLES` cycles after the calibration-start write. With `cmd_ready` high, the first command comes exactly `WAIT_CYCLES`+1 cycles after that write.
- R4: `cmd_word` carries the command code in bits 23:16 and the 16-bit argument in bits 15:0.
- R5: The first seven commands are, in order: deselect with argument 0, precharge with the precharge-all argument, extended mode register 2 with 0, extended mode register 3 with 0, extended mode register with the DLL-enable argument, mode register with the DLL-reset argument, and precharge with the precharge-all argument.
- R6: Two refresh commands with argument 0 follow. Then comes a mode-register command whose argument is `mode_val[15:0]`.
- R7: The last two commands are extended-mode-register writes. The first has argument DLL-enable | driver-default. The second has DLL-enable | driver-exit | `mode_val[31:16]`.
- R8: `cmd_valid` is high only in a cycle where `cmd_ready` is high. Each command is presented in exactly one such cycle. A low `cmd_ready` holds the sequence.
- R9: Between two commands there are at least `MIN_GAP` cycles with `cmd_valid` low. With `cmd_ready` high the gap is exactly `MIN_GAP`.
- R10: After the last command, three `reg_wr` pulses follow in consecutive cycles. They are `reg_sel`=0 with `timing_val`, then `reg_sel`=1 with `LATENCY_VAL` (0x13), then `reg_sel`=2 with `cfg_val`.
- R11: `done` rises the cycle after the configuration write and stays high until reset. A `start` while done produces no strobe.
- R12: A `start` pulse while the sequence is running is ignored and does not restart or repeat any step.
- R13: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches the sequence from idle |
| cmd_ready | input | 1 | Controller can accept a command this cycle |
| mode_val | input | 32 | Configured mode value (low half to MR, high half to final EMR) |
| timing_val | input | 32 | Value for the timing register write |
| cfg_val | input | 32 | Value for the configuration register write |
| phy_cfg_wr | output | 1 | PHY clock-enable write strobe |
| phy_ctrl_wr | output | 1 | PHY control write strobe |
| phy_ctrl_data | output | 3 | PHY control value: bit0 PHY reset, bit1 cal reset, bit2 cal start |
| cmd_valid | output | 1 | Command strobe |
| cmd_word | output | 24 | Command code (23:16) and argument (15:0) |
| reg_wr | output | 1 | Controller register write strobe |
| reg_sel | output | 2 | Register select: 0 timing, 1 latency, 2 configuration |
| reg_data | output | 32 | Register write value |
| done | output | 1 | Sequence complete, held until reset |

## Verification
The bench builds the sequencer with `WAIT_CYCLES`=40 and `MIN_GAP`=3, in place of the long default wait. With those values the exact power-up wait and the inter-command gaps can be timed cycle by cycle in a short run. The command codes and argument encodings are set to distinct non-zero values, so a swapped or misplaced command or OR term shows up in the compared words. A second run after a mid-life reset throttles `cmd_ready` in a periodic pattern and fires a stray `start` during the wait. This covers stalls, the minimum gap under back-pressure and the ignored start.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_PHY_CLK = 4'd1,
    ST_PHY_RST = 4'd2,
    ST_CAL     = 4'd3,
    ST_WAIT    = 4'd4,
    ST_CMD     = 4'd5,
    ST_GAP     = 4'd6,
    ST_REG_TIM = 4'd7,
    ST_REG_LAT = 4'd8,
    ST_REG_CFG = 4'd9,
    ST_DONE    = 4'd10
  } seq_state_e;

  // PHY control word layout
  localparam int PHY_CTRL_W  = 3;
  localparam int PHY_RST_BIT = 0;
  localparam int CAL_RST_BIT = 1;
  localparam int CAL_GO_BIT  = 2;

  // controller register selects
  localparam int          REG_SEL_W   = 2;
  localparam logic [1:0]  SEL_TIMING  = 2'd0;
  localparam logic [1:0]  SEL_LATENCY = 2'd1;
  localparam logic [1:0]  SEL_CONFIG  = 2'd2;

  // length of the memory command list
  localparam int NUM_CMDS = 12;

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_cmd_table.sv
module ddr2_init_cmd_table #(
  parameter int               CODE_W          = 8,
  parameter int               ARG_W           = 16,
  parameter int               IDX_W           = 4,
  parameter logic [CODE_W-1:0] CODE_DESELECT  = 8'h01,
  parameter logic [CODE_W-1:0] CODE_PRECHARGE = 8'h02,
  parameter logic [CODE_W-1:0] CODE_EMR2      = 8'h03,
  parameter logic [CODE_W-1:0] CODE_EMR3      = 8'h04,
  parameter logic [CODE_W-1:0] CODE_EMR       = 8'h05,
  parameter logic [CODE_W-1:0] CODE_MR        = 8'h06,
  parameter logic [CODE_W-1:0] CODE_REFRESH   = 8'h07,
  parameter logic [ARG_W-1:0]  ARG_PRE_ALL    = 16'h0400,
  parameter logic [ARG_W-1:0]  ARG_DLL_EN     = 16'h0000,
  parameter logic [ARG_W-1:0]  ARG_DLL_RST    = 16'h0100,
  parameter logic [ARG_W-1:0]  ARG_DRV_DFLT   = 16'h0380,
  parameter logic [ARG_W-1:0]  ARG_DRV_EXIT   = 16'h0000
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [2*ARG_W-1:0]      mode_val,
  output logic [CODE_W+ARG_W-1:0] word
);

  logic [CODE_W-1:0] code;
  logic [ARG_W-1:0]  arg;
  logic [ARG_W-1:0]  mode_lo;
  logic [ARG_W-1:0]  mode_hi;

  assign mode_lo = mode_val[ARG_W-1:0];
  assign mode_hi = mode_val[2*ARG_W-1:ARG_W];

  always_comb begin
    code = CODE_DESELECT;
    arg  = '0;
    case (int'(idx))
      0:  begin code = CODE_DESELECT;  arg = '0;                                    end
      1:  begin code = CODE_PRECHARGE; arg = ARG_PRE_ALL;                           end
      2:  begin code = CODE_EMR2;      arg = '0;                                    end
      3:  begin code = CODE_EMR3;      arg = '0;                                    end
      4:  begin code = CODE_EMR;       arg = ARG_DLL_EN;                            end
      5:  begin code = CODE_MR;        arg = ARG_DLL_RST;                           end
      6:  begin code = CODE_PRECHARGE; arg = ARG_PRE_ALL;                           end
      7:  begin code = CODE_REFRESH;   arg = '0;                                    end
      8:  begin code = CODE_REFRESH;   arg = '0;                                    end
      9:  begin code = CODE_MR;        arg = mode_lo;                               end
      10: begin code = CODE_EMR;       arg = ARG_DRV_DFLT | ARG_DLL_EN;             end
      11: begin code = CODE_EMR;       arg = ARG_DRV_EXIT | ARG_DLL_EN | mode_hi;   end
      default: begin code = CODE_DESELECT; arg = '0; end
    endcase
  end

  assign word = {code, arg};

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int                CODE_W         = 8,
  parameter int                ARG_W          = 16,
  parameter int                REG_W          = 32,
  parameter int                WAIT_CYCLES    = 10000,
  parameter int                MIN_GAP        = 2,
  parameter logic [CODE_W-1:0] CODE_DESELECT  = 8'h01,
  parameter logic [CODE_W-1:0] CODE_PRECHARGE = 8'h02,
  parameter logic [CODE_W-1:0] CODE_EMR2      = 8'h03,
  parameter logic [CODE_W-1:0] CODE_EMR3      = 8'h04,
  parameter logic [CODE_W-1:0] CODE_EMR       = 8'h05,
  parameter logic [CODE_W-1:0] CODE_MR        = 8'h06,
  parameter logic [CODE_W-1:0] CODE_REFRESH   = 8'h07,
  parameter logic [ARG_W-1:0]  ARG_PRE_ALL    = 16'h0400,
  parameter logic [ARG_W-1:0]  ARG_DLL_EN     = 16'h0000,
  parameter logic [ARG_W-1:0]  ARG_DLL_RST    = 16'h0100,
  parameter logic [ARG_W-1:0]  ARG_DRV_DFLT   = 16'h0380,
  parameter logic [ARG_W-1:0]  ARG_DRV_EXIT   = 16'h0000,
  parameter logic [REG_W-1:0]  LATENCY_VAL    = 32'h0000_0013
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cmd_ready,
  input  logic [2*ARG_W-1:0]      mode_val,
  input  logic [REG_W-1:0]        timing_val,
  input  logic [REG_W-1:0]        cfg_val,
  output logic                    phy_cfg_wr,
  output logic                    phy_ctrl_wr,
  output logic [2:0]              phy_ctrl_data,
  output logic                    cmd_valid,
  output logic [CODE_W+ARG_W-1:0] cmd_word,
  output logic                    reg_wr,
  output logic [1:0]              reg_sel,
  output logic [REG_W-1:0]        reg_data,
  output logic                    done
);

  localparam int  IDX_W     = $clog2(NUM_CMDS + 1);
  localparam int  TMR_MAX   = (WAIT_CYCLES > MIN_GAP) ? WAIT_CYCLES : MIN_GAP;
  localparam int  CNT_W     = $clog2(TMR_MAX + 1);
  localparam bit  HAS_GAP   = (MIN_GAP > 0);
  localparam int  GAP_LOAD  = HAS_GAP ? (MIN_GAP - 1) : 0;
  localparam int  WAIT_LOAD = (WAIT_CYCLES > 0) ? (WAIT_CYCLES - 1) : 0;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign srst_n = rst_sync_q[1];

  // state and command index
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             issue;
  logic             last_cmd;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  assign last_cmd = (idx_q == IDX_W'(NUM_CMDS - 1));

  always_comb begin
    state_d  = state_q;
    issue    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:    if (start) state_d = ST_PHY_CLK;
      ST_PHY_CLK: state_d = ST_PHY_RST;
      ST_PHY_RST: state_d = ST_CAL;
      ST_CAL: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WAIT_LOAD);
        state_d  = ST_WAIT;
      end
      ST_WAIT:    if (tmr_expired) state_d = ST_CMD;
      ST_CMD: begin
        if (cmd_ready) begin
          issue = 1'b1;
          if (HAS_GAP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(GAP_LOAD);
            state_d  = ST_GAP;
          end else begin
            state_d  = last_cmd ? ST_REG_TIM : ST_CMD;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          state_d = (idx_q == IDX_W'(NUM_CMDS)) ? ST_REG_TIM : ST_CMD;
        end
      end
      ST_REG_TIM: state_d = ST_REG_LAT;
      ST_REG_LAT: state_d = ST_REG_CFG;
      ST_REG_CFG: state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign idx_en = issue;
  assign idx_d  = idx_q + 1'b1;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  ddr2_init_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ddr2_init_cmd_table #(
    .CODE_W         (CODE_W),
    .ARG_W          (ARG_W),
    .IDX_W          (IDX_W),
    .CODE_DESELECT  (CODE_DESELECT),
    .CODE_PRECHARGE (CODE_PRECHARGE),
    .CODE_EMR2      (CODE_EMR2),
    .CODE_EMR3      (CODE_EMR3),
    .CODE_EMR       (CODE_EMR),
    .CODE_MR        (CODE_MR),
    .CODE_REFRESH   (CODE_REFRESH),
    .ARG_PRE_ALL    (ARG_PRE_ALL),
    .ARG_DLL_EN     (ARG_DLL_EN),
    .ARG_DLL_RST    (ARG_DLL_RST),
    .ARG_DRV_DFLT   (ARG_DRV_DFLT),
    .ARG_DRV_EXIT   (ARG_DRV_EXIT)
  ) u_cmd_table (
    .idx      (idx_q),
    .mode_val (mode_val),
    .word     (cmd_word)
  );

  // strobes decoded from state
  always_comb begin
    phy_cfg_wr    = (state_q == ST_PHY_CLK);
    phy_ctrl_wr   = (state_q == ST_PHY_RST) || (state_q == ST_CAL);
    phy_ctrl_data = '0;
    if (state_q == ST_PHY_RST) begin
      phy_ctrl_data[PHY_RST_BIT] = 1'b1;
      phy_ctrl_data[CAL_RST_BIT] = 1'b1;
    end
    if (state_q == ST_CAL) begin
      phy_ctrl_data[CAL_GO_BIT] = 1'b1;
    end
    cmd_valid = issue;
    reg_wr    = 1'b0;
    reg_sel   = SEL_TIMING;
    reg_data  = '0;
    case (state_q)
      ST_REG_TIM: begin reg_wr = 1'b1; reg_sel = SEL_TIMING;  reg_data = timing_val;  end
      ST_REG_LAT: begin reg_wr = 1'b1; reg_sel = SEL_LATENCY; reg_data = LATENCY_VAL; end
      ST_REG_CFG: begin reg_wr = 1'b1; reg_sel = SEL_CONFIG;  reg_data = cfg_val;     end
      default: ;
    endcase
    done = (state_q == ST_DONE);
  end

endmodule

module ddr2_init_seq_chk #(
  parameter int WAIT_CYCLES = 10000,
  parameter int MIN_GAP     = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_cfg_wr,
  input logic       phy_ctrl_wr,
  input logic [2:0] phy_ctrl_data,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic       done
);

  localparam int WCNT_W = $clog2(WAIT_CYCLES + 1);
  localparam int GCNT_W = $clog2(MIN_GAP + 2);

  logic              cal_seen;
  logic [WCNT_W-1:0] wait_cnt;
  logic              cmd_seen;
  logic [GCNT_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_seen <= 1'b0;
      wait_cnt <= '0;
    end else if (phy_ctrl_wr && phy_ctrl_data == 3'b100) begin
      cal_seen <= 1'b1;
      wait_cnt <= '0;
    end else if (cal_seen && wait_cnt != WCNT_W'(WAIT_CYCLES)) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_seen <= 1'b0;
      gap_cnt  <= '0;
    end else if (cmd_valid) begin
      cmd_seen <= 1'b1;
      gap_cnt  <= '0;
    end else if (gap_cnt != GCNT_W'(MIN_GAP)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  a_r2_clk_then_reset: assert property (@(posedge clk) disable iff (!rst_n)
    phy_cfg_wr |=> (phy_ctrl_wr && phy_ctrl_data == 3'b011));

  a_r2_reset_then_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl_wr && phy_ctrl_data == 3'b011) |=> (phy_ctrl_wr && phy_ctrl_data == 3'b100));

  a_r3_wait_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cal_seen && wait_cnt == WCNT_W'(WAIT_CYCLES)));

  a_r8_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_ready);

  a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_seen) |-> (gap_cnt == GCNT_W'(MIN_GAP)));

  a_r10_timing_then_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (reg_wr && reg_sel == 2'd1));

  a_r10_latency_then_config: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (reg_wr && reg_sel == 2'd2));

  a_r11_done_after_config: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=> done);

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r11_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(phy_cfg_wr || phy_ctrl_wr || cmd_valid || reg_wr));

  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cfg_wr, phy_ctrl_wr, cmd_valid, reg_wr}));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .WAIT_CYCLES (WAIT_CYCLES),
  .MIN_GAP     (MIN_GAP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phy_cfg_wr    (phy_cfg_wr),
  .phy_ctrl_wr   (phy_ctrl_wr),
  .phy_ctrl_data (phy_ctrl_data),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .reg_wr        (reg_wr),
  .reg_sel       (reg_sel),
  .done          (done)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_T     = 40;
  localparam int GAP_T      = 3;
  localparam int WD_LIMIT   = 20000;

  localparam logic [7:0]  C_DESEL = 8'h17;
  localparam logic [7:0]  C_PRE   = 8'h22;
  localparam logic [7:0]  C_EMR2  = 8'h32;
  localparam logic [7:0]  C_EMR3  = 8'h33;
  localparam logic [7:0]  C_EMR   = 8'h31;
  localparam logic [7:0]  C_MR    = 8'h30;
  localparam logic [7:0]  C_REF   = 8'h41;
  localparam logic [15:0] A_PALL  = 16'h0400;
  localparam logic [15:0] A_DLLEN = 16'h0004;
  localparam logic [15:0] A_DLLRS = 16'h0100;
  localparam logic [15:0] A_DDFLT = 16'h0380;
  localparam logic [15:0] A_DEXIT = 16'h0008;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        cmd_ready;
  logic [31:0] mode_val;
  logic [31:0] timing_val;
  logic [31:0] cfg_val;
  logic        phy_cfg_wr;
  logic        phy_ctrl_wr;
  logic [2:0]  phy_ctrl_data;
  logic        cmd_valid;
  logic [23:0] cmd_word;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_data;
  logic        done;

  ddr2_init_seq #(
    .WAIT_CYCLES    (WAIT_T),
    .MIN_GAP        (GAP_T),
    .CODE_DESELECT  (C_DESEL),
    .CODE_PRECHARGE (C_PRE),
    .CODE_EMR2      (C_EMR2),
    .CODE_EMR3      (C_EMR3),
    .CODE_EMR       (C_EMR),
    .CODE_MR        (C_MR),
    .CODE_REFRESH   (C_REF),
    .ARG_PRE_ALL    (A_PALL),
    .ARG_DLL_EN     (A_DLLEN),
    .ARG_DLL_RST    (A_DLLRS),
    .ARG_DRV_DFLT   (A_DDFLT),
    .ARG_DRV_EXIT   (A_DEXIT)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cmd_ready     (cmd_ready),
    .mode_val      (mode_val),
    .timing_val    (timing_val),
    .cfg_val       (cfg_val),
    .phy_cfg_wr    (phy_cfg_wr),
    .phy_ctrl_wr   (phy_ctrl_wr),
    .phy_ctrl_data (phy_ctrl_data),
    .cmd_valid     (cmd_valid),
    .cmd_word      (cmd_word),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_data      (reg_data),
    .done          (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard item: kind 0 phy clock, 1 phy ctrl, 2 command, 3 register
  typedef struct {
    int          kind;
    logic [33:0] data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  int cal_cyc  = 0;
  int last_cmd_cyc = 0;
  bit cmd_seen = 0;
  bit exact    = 0;
  bit stall    = 0;
  bit prev_cfg = 0;
  bit finished = 0;
  int wd       = 0;
  int rk       = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [33:0] data, input string tag);
    exp_t e;
    e.kind = kind;
    e.data = data;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic load_expected(input logic [31:0] mv, input logic [31:0] tv,
                               input logic [31:0] cv);
    push(0, 34'd0, "R2");
    push(1, 34'h3, "R2");
    push(1, 34'h4, "R2");
    push(2, {10'd0, C_DESEL, 16'h0000}, "R5_R4");
    push(2, {10'd0, C_PRE,   A_PALL},   "R5");
    push(2, {10'd0, C_EMR2,  16'h0000}, "R5");
    push(2, {10'd0, C_EMR3,  16'h0000}, "R5");
    push(2, {10'd0, C_EMR,   A_DLLEN},  "R5");
    push(2, {10'd0, C_MR,    A_DLLRS},  "R5");
    push(2, {10'd0, C_PRE,   A_PALL},   "R5");
    push(2, {10'd0, C_REF,   16'h0000}, "R6");
    push(2, {10'd0, C_REF,   16'h0000}, "R6");
    push(2, {10'd0, C_MR,    mv[15:0]}, "R6");
    push(2, {10'd0, C_EMR,   A_DLLEN | A_DDFLT}, "R7");
    push(2, {10'd0, C_EMR,   A_DLLEN | A_DEXIT | mv[31:16]}, "R7");
    push(3, {2'd0, tv},          "R10");
    push(3, {2'd1, 32'h13},      "R10");
    push(3, {2'd2, cv},          "R10");
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    rk++;
    cmd_ready = stall ? ((rk % 9) < 5) : 1'b1;
  end

  // monitor: compares each strobe against the scoreboard queue
  always @(negedge clk) begin
    int          nstr;
    int          kind;
    logic [33:0] data;
    exp_t        e;
    if (!rst_n) begin
      cmd_seen = 0;
      prev_cfg = 0;
    end else begin
      cyc++;
      if (prev_cfg) check(done == 1'b1, "R11", "done after config write", 64'(done), 64'd1);
      prev_cfg = reg_wr && (reg_sel == 2'd2);
      nstr = int'(phy_cfg_wr) + int'(phy_ctrl_wr) + int'(cmd_valid) + int'(reg_wr);
      if (nstr > 1) begin
        check(0, "R13", "several strobes in one cycle", 64'(nstr), 64'd1);
      end else if (nstr == 1) begin
        kind = 0;
        data = '0;
        if (phy_ctrl_wr) begin kind = 1; data = {31'd0, phy_ctrl_data}; end
        if (cmd_valid)   begin kind = 2; data = {10'd0, cmd_word}; end
        if (reg_wr)      begin kind = 3; data = {reg_sel, reg_data}; end
        if (cmd_valid) begin
          check(cmd_ready == 1'b1, "R8", "command while not ready", 64'(cmd_ready), 64'd1);
          if (!cmd_seen) begin
            if (exact) check((cyc - cal_cyc) == WAIT_T + 1, "R3", "power-up wait length",
                             64'(cyc - cal_cyc), 64'(WAIT_T + 1));
            else       check((cyc - cal_cyc) >= WAIT_T + 1, "R3", "power-up wait too short",
                             64'(cyc - cal_cyc), 64'(WAIT_T + 1));
          end else begin
            if (exact) check((cyc - last_cmd_cyc) == GAP_T + 1, "R9", "command spacing",
                             64'(cyc - last_cmd_cyc), 64'(GAP_T + 1));
            else       check((cyc - last_cmd_cyc) >= GAP_T + 1, "R9", "command spacing too short",
                             64'(cyc - last_cmd_cyc), 64'(GAP_T + 1));
          end
          cmd_seen = 1;
          last_cmd_cyc = cyc;
        end
        if (phy_ctrl_wr && phy_ctrl_data[2]) cal_cyc = cyc;
        if (exp_q.size() == 0) begin
          check(0, "R12", "unexpected strobe", {30'd0, data}, 64'(kind));
        end else begin
          e = exp_q.pop_front();
          check(kind == e.kind && data == e.data, e.tag, "strobe content",
                {28'(kind), 2'd0, data}, {28'(e.kind), 2'd0, e.data});
        end
      end
      if (done && exp_q.size() != 0)
        check(0, "R11", "done before sequence end", 64'(exp_q.size()), 64'd0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT && !finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL R11: watchdog expired, done=%0d expected=1", done);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic check_reset_outputs(input string what);
    check({phy_cfg_wr, phy_ctrl_wr, cmd_valid, reg_wr, done} == 5'b0, "R1", what,
          64'({phy_cfg_wr, phy_ctrl_wr, cmd_valid, reg_wr, done}), 64'd0);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    cmd_ready  = 1'b1;
    mode_val   = 32'hA5C3_1E07;
    timing_val = 32'h1234_5678;
    cfg_val    = 32'h0BAD_F00D;
    repeat (4) @(posedge clk);
    #1;
    check_reset_outputs("outputs during reset");
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check_reset_outputs("outputs idle after reset");

    // run 1: ready always high, exact timing
    exact = 1;
    stall = 0;
    load_expected(mode_val, timing_val, cfg_val);
    pulse_start();
    wait_done();
    repeat (5) @(posedge clk);
    pulse_start();               // R11: start after done is ignored
    repeat (20) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R10", "run 1 sequence complete", 64'(exp_q.size()), 64'd0);
    check(done == 1'b1, "R11", "done held after run 1", 64'(done), 64'd1);

    // reset in the done state
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_reset_outputs("outputs after reset from done");
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check_reset_outputs("idle after second reset");

    // run 2: throttled ready, stray start during the wait
    exact      = 0;
    stall      = 1;
    mode_val   = 32'h0240_0C52;
    timing_val = 32'hCAFE_0001;
    cfg_val    = 32'h7700_3311;
    load_expected(mode_val, timing_val, cfg_val);
    pulse_start();
    repeat (10) @(posedge clk);
    pulse_start();               // R12: ignored while running
    wait_done();
    repeat (10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R10", "run 2 sequence complete", 64'(exp_q.size()), 64'd0);
    check(done == 1'b1, "R11", "done held after run 2", 64'(done), 64'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule